// File: doc/BRIEF.md
# Blackjack Dealer Hand Controller

This block plays a single dealer hand of blackjack. It raises a request for a card, takes one 5-bit card code per accepted strobe, and checks the code's range. It adds the card to a running total, counts it, and then either asks for another card or settles the hand as standing or bust. An ace goes through its own path. It is first worth eleven points, and it drops to one point when keeping it at eleven would push the hand past twenty-one.

Each step of the hand takes its own clock cycle. A card is latched in one cycle and added in the next. A possible ace reduction follows, and only after that is the total compared with the standing threshold. A final cycle chooses between stand and bust. Error, bust and stand are terminal states. A synchronous reset clears everything and starts a fresh hand.

Top module: `dealer_hand_ctrl`

## Requirements
- R1: While the synchronous reset is high, the total, the card count and the stand, bust and error flags are all driven to zero. In the first cycle after reset is released, the card request is high.
- R2: Suppose a card is offered while the request is high and its code is 0, 1, or any value from 12 to 31. The next cycle then shows the error flag high and the request low. The total and count stay unchanged, and the error flag holds until reset.
- R3: A card code from 2 to 10 is accepted while the request is high. Two cycles after the accepting edge, that code's value has been added to the total and the card count has risen by one.
- R4: Code 11 is an ace. Two cycles after acceptance it has added 11 to the total and 1 to the count, and the hand then holds one more ace that is still worth eleven.
- R5: The total can exceed 21 while at least one ace is still worth eleven. In that case, three cycles after acceptance the total has dropped by 10 and that ace now counts as one.
- R6: The request falls in the cycle right after a card is accepted. Card strobes offered while the request is low have no effect.
- R7: The comparison with 17 uses the total after the new card and any ace reduction. A total below 17 raises the request again four cycles after acceptance.
- R8: Suppose the checked total is at least 17 and no more than 21. Five cycles after acceptance the stand flag rises, and it holds until reset.
- R9: Suppose the checked total is above 21. Five cycles after acceptance the bust flag rises, and it holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; starts a new hand |
| cardValid | input | 1 | Strobe marking that cardCode holds a card |
| cardCode | input | 5 | Card value code (2..10 plain, 11 ace) |
| hitReq | output | 1 | High while the controller waits for a card |
| standFlag | output | 1 | Hand finished at 17..21 |
| bustFlag | output | 1 | Hand finished above 21 |
| errFlag | output | 1 | An invalid card code was offered |
| handTotal | output | 6 | Current point total |
| cardCount | output | 4 | Number of accepted cards |

## Verification
A wrong state or a lost ace credit inside this controller reaches the ports within a few cycles. A skipped or repeated step moves the rise of the request or of a final flag by one or more cycles. A missing reduction leaves the total ten too high three cycles after the card, and it turns a stand into a bust. The bench therefore compares every output on every cycle against a behavioural model. Any timing slip fails at the first cycle where it appears. Hands cover plain cards, single and double aces, a late ace that must shrink at once, exact totals of 17, 21 and 22, invalid codes at both ends, and strobes held high while no card is requested.

// File: rtl/dealer_pkg.sv
package dealer_pkg;

  typedef enum logic [3:0] {
    ST_REQ,
    ST_ADD,
    ST_ACE,
    ST_CHK,
    ST_EVAL,
    ST_DECIDE,
    ST_STAND,
    ST_BUST,
    ST_ERR
  } handState_t;

  typedef struct packed {
    logic loadCard;
    logic addCard;
    logic addAce;
    logic fixSoft;
  } dpStrobe_t;

endpackage

// File: rtl/dealer_datapath.sv
module dealer_datapath
  import dealer_pkg::*;
#(
  parameter int CODE_W     = 5,
  parameter int TOTAL_W    = 6,
  parameter int CNT_W      = 4,
  parameter int SOFT_W     = 3,
  parameter int MIN_CODE   = 2,
  parameter int MAX_CODE   = 11,
  parameter int ACE_CODE   = 11,
  parameter int ACE_DROP   = 10,
  parameter int STAND_AT   = 17,
  parameter int BUST_ABOVE = 21
) (
  input  logic               clk,
  input  logic               rst,
  input  dpStrobe_t          strobe,
  input  logic [CODE_W-1:0]  cardCode,
  output logic               codeBad,
  output logic               codeAce,
  output logic               overLimit,
  output logic               reachStand,
  output logic [TOTAL_W-1:0] handTotal,
  output logic [CNT_W-1:0]   cardCount
);

  localparam logic [CODE_W-1:0]  MinC   = CODE_W'(MIN_CODE);
  localparam logic [CODE_W-1:0]  MaxC   = CODE_W'(MAX_CODE);
  localparam logic [CODE_W-1:0]  AceC   = CODE_W'(ACE_CODE);
  localparam logic [TOTAL_W-1:0] AceVal = TOTAL_W'(ACE_CODE);
  localparam logic [TOTAL_W-1:0] DropV  = TOTAL_W'(ACE_DROP);
  localparam logic [TOTAL_W-1:0] StandV = TOTAL_W'(STAND_AT);
  localparam logic [TOTAL_W-1:0] BustV  = TOTAL_W'(BUST_ABOVE);
  localparam logic [TOTAL_W-1:0] PeakV  = TOTAL_W'(STAND_AT - 1 + MAX_CODE);

  logic [CODE_W-1:0]  cardReg;
  logic [TOTAL_W-1:0] totalQ;
  logic [CNT_W-1:0]   countQ;
  logic [SOFT_W-1:0]  softAces;

  assign codeBad    = (cardCode < MinC) || (cardCode > MaxC);
  assign codeAce    = (cardCode == AceC);
  assign overLimit  = totalQ > BustV;
  assign reachStand = totalQ >= StandV;
  assign handTotal  = totalQ;
  assign cardCount  = countQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      cardReg  <= '0;
      totalQ   <= '0;
      countQ   <= '0;
      softAces <= '0;
    end else begin
      if (strobe.loadCard) cardReg <= cardCode;
      if (strobe.addCard) begin
        totalQ <= totalQ + TOTAL_W'(cardReg);
        countQ <= countQ + 1'b1;
      end
      if (strobe.addAce) begin
        totalQ   <= totalQ + AceVal;
        countQ   <= countQ + 1'b1;
        softAces <= softAces + 1'b1;
      end
      if (strobe.fixSoft && overLimit && (softAces != '0)) begin
        totalQ   <= totalQ - DropV;
        softAces <= softAces - 1'b1;
      end
    end
  end

  // R5
  total_peak_chk: assert property (@(posedge clk) disable iff (rst)
    handTotal <= PeakV);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cardCount != $past(cardCount)) |-> (cardCount == $past(cardCount) + 1'b1));

  // R5
  soft_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.fixSoft && overLimit && softAces != '0) |=> (handTotal == $past(handTotal) - DropV));

endmodule

// File: rtl/dealer_control.sv
module dealer_control
  import dealer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cardValid,
  input  logic      codeBad,
  input  logic      codeAce,
  input  logic      overLimit,
  input  logic      reachStand,
  output dpStrobe_t strobe,
  output logic      hitReq,
  output logic      standFlag,
  output logic      bustFlag,
  output logic      errFlag
);

  handState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_REQ:    if (cardValid) stateD = codeBad ? ST_ERR : (codeAce ? ST_ACE : ST_ADD);
      ST_ADD:    stateD = ST_CHK;
      ST_ACE:    stateD = ST_CHK;
      ST_CHK:    stateD = ST_EVAL;
      ST_EVAL:   stateD = reachStand ? ST_DECIDE : ST_REQ;
      ST_DECIDE: stateD = overLimit ? ST_BUST : ST_STAND;
      default:   stateD = stateQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_REQ;
    else     stateQ <= stateD;
  end

  always_comb begin
    strobe.loadCard = (stateQ == ST_REQ) && cardValid && !codeBad;
    strobe.addCard  = (stateQ == ST_ADD);
    strobe.addAce   = (stateQ == ST_ACE);
    strobe.fixSoft  = (stateQ == ST_CHK);
  end

  assign hitReq    = (stateQ == ST_REQ);
  assign standFlag = (stateQ == ST_STAND);
  assign bustFlag  = (stateQ == ST_BUST);
  assign errFlag   = (stateQ == ST_ERR);

  // R6
  hit_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (hitReq && cardValid) |=> !hitReq);

  // R2
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag);

  // R8
  stand_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    standFlag |=> standFlag);

  // R9
  bust_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    bustFlag |=> bustFlag);

  // R2
  bad_code_chk: assert property (@(posedge clk) disable iff (rst)
    (hitReq && cardValid && codeBad) |=> errFlag);

endmodule

// File: rtl/dealer_hand_ctrl.sv
module dealer_hand_ctrl
  import dealer_pkg::*;
#(
  parameter int CODE_W     = 5,
  parameter int TOTAL_W    = 6,
  parameter int CNT_W      = 4,
  parameter int SOFT_W     = 3,
  parameter int MIN_CODE   = 2,
  parameter int MAX_CODE   = 11,
  parameter int ACE_CODE   = 11,
  parameter int ACE_DROP   = 10,
  parameter int STAND_AT   = 17,
  parameter int BUST_ABOVE = 21
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cardValid,
  input  logic [CODE_W-1:0]  cardCode,
  output logic               hitReq,
  output logic               standFlag,
  output logic               bustFlag,
  output logic               errFlag,
  output logic [TOTAL_W-1:0] handTotal,
  output logic [CNT_W-1:0]   cardCount
);

  dpStrobe_t strobe;
  logic      codeBad, codeAce, overLimit, reachStand;

  dealer_control i_control (
    .clk        (clk),
    .rst        (rst),
    .cardValid  (cardValid),
    .codeBad    (codeBad),
    .codeAce    (codeAce),
    .overLimit  (overLimit),
    .reachStand (reachStand),
    .strobe     (strobe),
    .hitReq     (hitReq),
    .standFlag  (standFlag),
    .bustFlag   (bustFlag),
    .errFlag    (errFlag)
  );

  dealer_datapath #(
    .CODE_W     (CODE_W),
    .TOTAL_W    (TOTAL_W),
    .CNT_W      (CNT_W),
    .SOFT_W     (SOFT_W),
    .MIN_CODE   (MIN_CODE),
    .MAX_CODE   (MAX_CODE),
    .ACE_CODE   (ACE_CODE),
    .ACE_DROP   (ACE_DROP),
    .STAND_AT   (STAND_AT),
    .BUST_ABOVE (BUST_ABOVE)
  ) i_datapath (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .cardCode   (cardCode),
    .codeBad    (codeBad),
    .codeAce    (codeAce),
    .overLimit  (overLimit),
    .reachStand (reachStand),
    .handTotal  (handTotal),
    .cardCount  (cardCount)
  );

endmodule

// File: tb/test_dealer_hand_ctrl.sv
module test_dealer_hand_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cardValid = 1'b0;
  logic [4:0] cardCode = '0;
  logic       hitReq, standFlag, bustFlag, errFlag;
  logic [5:0] handTotal;
  logic [3:0] cardCount;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  dealer_hand_ctrl i_dealer_hand_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cardValid (cardValid),
    .cardCode  (cardCode),
    .hitReq    (hitReq),
    .standFlag (standFlag),
    .bustFlag  (bustFlag),
    .errFlag   (errFlag),
    .handTotal (handTotal),
    .cardCount (cardCount)
  );

  // Behavioural reference: phase 0 waiting, 1 adding, 2 ace check,
  // 3 threshold, 4 outcome, 5 stood, 6 bust, 7 error
  int mPhase = 0, mTotal = 0, mCount = 0, mSoft = 0, mPend = 0;

  always @(posedge clk) begin
    if (rst) begin
      mPhase = 0; mTotal = 0; mCount = 0; mSoft = 0; mPend = 0;
    end else begin
      case (mPhase)
        0: if (cardValid) begin
             if (cardCode < 2 || cardCode > 11) mPhase = 7;
             else begin mPend = int'(cardCode); mPhase = 1; end
           end
        1: begin
             mTotal += mPend;
             if (mPend == 11) mSoft++;
             mCount++;
             mPhase = 2;
           end
        2: begin
             if (mTotal > 21 && mSoft > 0) begin mTotal -= 10; mSoft--; end
             mPhase = 3;
           end
        3: mPhase = (mTotal >= 17) ? 4 : 0;
        4: mPhase = (mTotal > 21) ? 6 : 5;
        default: ;
      endcase
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("R6 R7", "hitReq", int'(hitReq), int'(mPhase == 0));
    check("R8", "standFlag", int'(standFlag), int'(mPhase == 5));
    check("R9", "bustFlag", int'(bustFlag), int'(mPhase == 6));
    check("R2", "errFlag", int'(errFlag), int'(mPhase == 7));
    check("R3", "handTotal", int'(handTotal), mTotal);
    check("R3", "cardCount", int'(cardCount), mCount);
  endtask

  // outcome: 0 stand, 1 bust, 2 error
  task automatic playHand(string req, int cards[$], bit noise,
                          int expTotal, int expCount, int outcome);
    int idx = 0;
    int settle = 0;
    rst = 1'b1; cardValid = 1'b0; cardCode = '0;
    repeat (2) @(negedge clk);
    // R1: reset values seen while reset is still high
    check("R1", "total in reset", int'(handTotal), 0);
    check("R1", "flags in reset", int'({standFlag, bustFlag, errFlag}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "hitReq after reset", int'(hitReq), 1);
    check("R1", "count after reset", int'(cardCount), 0);
    for (int cyc = 0; cyc < 80; cyc++) begin
      compareAll();
      if (mPhase >= 5) settle++;
      if (settle == 3) break;
      if (mPhase == 0 && idx < cards.size()) begin
        cardValid = 1'b1; cardCode = 5'(cards[idx]); idx++;
      end else if (noise && mPhase != 0) begin
        cardValid = 1'b1; cardCode = 5'd0;
      end else begin
        cardValid = 1'b0; cardCode = '0;
      end
      @(negedge clk);
    end
    cardValid = 1'b0;
    check(req, "final total", int'(handTotal), expTotal);
    check(req, "final count", int'(cardCount), expCount);
    check(req, "final stand", int'(standFlag), int'(outcome == 0));
    check(req, "final bust", int'(bustFlag), int'(outcome == 1));
    check(req, "final error", int'(errFlag), int'(outcome == 2));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    playHand("R3 R8", '{10, 7}, 1'b0, 17, 2, 0);
    playHand("R9 R7", '{10, 6, 9}, 1'b0, 25, 3, 1);
    playHand("R4", '{11, 6}, 1'b0, 17, 2, 0);
    playHand("R5", '{11, 5, 9, 2}, 1'b0, 17, 4, 0);
    playHand("R5 double ace", '{11, 11, 5}, 1'b0, 17, 3, 0);
    playHand("R5 late ace", '{8, 8, 11}, 1'b0, 17, 3, 0);
    playHand("R6 ignored strobes", '{2, 2, 2, 2, 2, 2, 2, 2, 2}, 1'b1, 18, 9, 0);
    playHand("R4 exact 21", '{10, 11}, 1'b0, 21, 2, 0);
    playHand("R9 exact 22", '{10, 2, 10}, 1'b1, 22, 3, 1);
    playHand("R2 code 0", '{9, 0}, 1'b0, 9, 1, 2);
    playHand("R2 code 12", '{12}, 1'b0, 0, 0, 2);
    playHand("R2 code 1", '{1}, 1'b0, 0, 0, 2);
    playHand("R2 code 31", '{5, 31}, 1'b0, 5, 1, 2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule